// File: doc/BRIEF.md
# Bus Request Issue Gate

This block sits inside a symmetric agent on a shared multi-agent system bus. Every bus clock it decides whether the agent may start a new transaction. It registers four active-low bus conditions on the rising clock edge: the shared stall line, the priority-agent request, the snoop hit pair, and the lock line. From these it produces one active-high issue permit. It also drives its own active-low contribution to the shared stall line, on behalf of the agent's queue logic.

The shared stall line is wire-OR among all agents. To keep several drivers from switching in the same edge, the block drives and samples it on separate clock slots. Slot 0 is the first rising edge after reset. With the default two-clock cadence, the agent's stall wish is taken on even edges and the shared line is read on odd edges; each value is held until its slot comes round again. The block also tracks a locked sequence that the agent has started. While that sequence runs, the agent may keep issuing even though the priority agent has asked for the bus.

Top module: `bus_issue_gate`

## Requirements
- R1: While rst_ni is low, issue_ok_o is 1 and stall_drive_no is 1, and the locked flag is clear.
- R2: stall_drive_no changes only after an edge whose slot number (edges counted from 0 after reset, modulo PERIOD) equals DRIVE_SLOT (default 0). After such an edge it equals the inverse of the stall_req_i value sampled there.
- R3: stall_ni is captured only on edges of slot SAMPLE_SLOT (default 1). While the captured value is 0 (stall active), issue_ok_o is 0.
- R4: When hit_ni and hitm_ni are both 0 at an edge, issue_ok_o is 0 for the following cycle. Either one alone being 0 does not affect issue_ok_o.
- R5: When prio_ni is 0 at an edge and the locked flag is clear after that edge, issue_ok_o is 0 for the following cycle.
- R6: An edge where issue_i=1, issue_lock_i=1 and issue_ok_o=1, with the flag clear, sets the locked flag. While the flag is set, prio_ni has no effect on issue_ok_o.
- R7: With the flag set, lock_done_i=1 at an edge clears it.
- R8: With the flag set, lock_ni sampled 1 (lock line released) at an edge clears it.
- R9: A locked issue attempt while issue_ok_o is 0 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_ni | input | 1 | Shared bus stall line, active low |
| prio_ni | input | 1 | Priority-agent request, active low |
| lock_ni | input | 1 | Bus lock line, active low |
| hit_ni | input | 1 | Snoop hit, active low |
| hitm_ni | input | 1 | Snoop hit-modified, active low |
| stall_req_i | input | 1 | Agent wishes to stall the bus |
| issue_i | input | 1 | Agent starts a transaction this cycle |
| issue_lock_i | input | 1 | The transaction being started is locked |
| lock_done_i | input | 1 | Last locked transaction completes |
| issue_ok_o | output | 1 | Permit to start a new transaction |
| stall_drive_no | output | 1 | Agent's drive onto the stall line, active low |

## Verification
The bench builds the block with its defaults: PERIOD of 2, drive slot 0 and sample slot 1. This exposes the alternation of the drive and sample slots on every pair of edges, so a stall pulse that lasts one clock is seen or missed depending on its phase. Directed segments walk a locked sequence through each of its exits while the priority request is held. A long random segment brings snoop stalls, stall samples and lock releases into the same cycles.

// File: rtl/big_pkg.sv
package big_pkg;
  typedef struct packed {
    logic stall;  // shared stall seen active in last sample slot
    logic snoop;  // snoop stall seen at last edge
    logic prio;   // priority request seen at last edge
  } bus_view_t;
endpackage

// File: rtl/big_phase_seq.sv
module big_phase_seq #(
  parameter int unsigned PERIOD      = 2,
  parameter int unsigned DRIVE_SLOT  = 0,
  parameter int unsigned SAMPLE_SLOT = 1,
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            drive_slot_o,
  output logic            sample_slot_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] DRV  = PH_W'(DRIVE_SLOT);
  localparam logic [PH_W-1:0] SMP  = PH_W'(SAMPLE_SLOT);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (phase_q == LAST)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign phase_o       = phase_q;
  assign drive_slot_o  = (phase_q == DRV);
  assign sample_slot_o = (phase_q == SMP);
endmodule

// File: rtl/big_sampler.sv
module big_sampler
  import big_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sample_slot_i,
  input  logic      stall_ni,
  input  logic      prio_ni,
  input  logic      hit_ni,
  input  logic      hitm_ni,
  output bus_view_t view_o
);
  bus_view_t view_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      view_q <= '0;
    end else begin
      view_q.snoop <= ~hit_ni & ~hitm_ni;
      view_q.prio  <= ~prio_ni;
      // wire-OR line is read only in its own slot
      if (sample_slot_i) view_q.stall <= ~stall_ni;
    end
  end

  assign view_o = view_q;
endmodule

// File: rtl/big_lock_track.sv
module big_lock_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic permit_i,
  input  logic issue_i,
  input  logic issue_lock_i,
  input  logic lock_done_i,
  input  logic lock_ni,
  output logic locked_o
);
  logic locked_q, locked_d;

  always_comb begin
    if (!locked_q) locked_d = issue_i & issue_lock_i & permit_i;
    else           locked_d = ~(lock_done_i | lock_ni);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) locked_q <= 1'b0;
    else         locked_q <= locked_d;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/bus_issue_gate.sv
module bus_issue_gate #(
  parameter int unsigned PERIOD      = 2,
  parameter int unsigned DRIVE_SLOT  = 0,
  parameter int unsigned SAMPLE_SLOT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_ni,
  input  logic prio_ni,
  input  logic lock_ni,
  input  logic hit_ni,
  input  logic hitm_ni,
  input  logic stall_req_i,
  input  logic issue_i,
  input  logic issue_lock_i,
  input  logic lock_done_i,
  output logic issue_ok_o,
  output logic stall_drive_no
);
  import big_pkg::*;
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] phase_q;
  logic            drive_slot, sample_slot;
  bus_view_t       view;
  logic            locked_q;
  logic            drive_q;
  logic            stall_seen;

  big_phase_seq #(
    .PERIOD(PERIOD), .DRIVE_SLOT(DRIVE_SLOT), .SAMPLE_SLOT(SAMPLE_SLOT)
  ) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase_q),
    .drive_slot_o(drive_slot), .sample_slot_o(sample_slot)
  );

  big_sampler u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_slot_i(sample_slot),
    .stall_ni(stall_ni), .prio_ni(prio_ni), .hit_ni(hit_ni), .hitm_ni(hitm_ni),
    .view_o(view)
  );

  big_lock_track u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .permit_i(issue_ok_o),
    .issue_i(issue_i), .issue_lock_i(issue_lock_i),
    .lock_done_i(lock_done_i), .lock_ni(lock_ni), .locked_o(locked_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         drive_q <= 1'b0;
    else if (drive_slot) drive_q <= stall_req_i;
  end

  assign stall_seen     = view.stall;
  assign stall_drive_no = ~drive_q;
  assign issue_ok_o     = ~view.stall & ~view.snoop & (~view.prio | locked_q);
endmodule

// File: rtl/big_checker.sv
module big_checker #(
  parameter int unsigned PERIOD      = 2,
  parameter int unsigned DRIVE_SLOT  = 0,
  parameter int unsigned SAMPLE_SLOT = 1,
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            prio_ni,
  input logic            lock_ni,
  input logic            hit_ni,
  input logic            hitm_ni,
  input logic            issue_i,
  input logic            issue_lock_i,
  input logic            lock_done_i,
  input logic            issue_ok_o,
  input logic            stall_drive_no,
  input logic [PH_W-1:0] phase_q,
  input logic            stall_seen,
  input logic            locked_q
);
  localparam logic [PH_W-1:0] DRV = PH_W'(DRIVE_SLOT);
  localparam logic [PH_W-1:0] SMP = PH_W'(SAMPLE_SLOT);

  always_comb if (!rst_ni) p_reset_r1: assert (issue_ok_o && stall_drive_no && !locked_q);

  p_drive_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != DRV) |=> $stable(stall_drive_no));

  p_sample_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != SMP) |=> $stable(stall_seen));

  p_stall_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_seen |-> !issue_ok_o);

  p_snoop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_ni && !hitm_ni) |=> !issue_ok_o);

  p_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prio_ni && !locked_q && !(issue_i && issue_lock_i)) |=> !issue_ok_o);

  p_lock_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && issue_i && issue_lock_i && issue_ok_o) |=> locked_q);

  p_lock_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && lock_done_i) |=> !locked_q);

  p_lock_rel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && lock_ni) |=> !locked_q);

  p_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !issue_ok_o) |=> !locked_q);
endmodule

bind bus_issue_gate big_checker #(
  .PERIOD(PERIOD), .DRIVE_SLOT(DRIVE_SLOT), .SAMPLE_SLOT(SAMPLE_SLOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prio_ni(prio_ni), .lock_ni(lock_ni),
  .hit_ni(hit_ni), .hitm_ni(hitm_ni), .issue_i(issue_i),
  .issue_lock_i(issue_lock_i), .lock_done_i(lock_done_i),
  .issue_ok_o(issue_ok_o), .stall_drive_no(stall_drive_no),
  .phase_q(phase_q), .stall_seen(stall_seen), .locked_q(locked_q)
);

// File: tb/tb_bus_issue_gate.sv
module tb_bus_issue_gate;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic stall_ni = 1, prio_ni = 1, lock_ni = 1, hit_ni = 1, hitm_ni = 1;
  logic stall_req_i = 0, issue_i = 0, issue_lock_i = 0, lock_done_i = 0;
  logic issue_ok_o, stall_drive_no;

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  // behavioural reference state
  int  m_edge;
  bit  m_stall, m_snoop, m_prio, m_lock, m_drive;

  always #2 clk_i = ~clk_i;

  bus_issue_gate dut (.*);

  function automatic bit m_permit();
    return !m_stall && !m_snoop && (!m_prio || m_lock);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edge = 0; m_stall = 0; m_snoop = 0; m_prio = 0; m_lock = 0; m_drive = 0;
    end else begin
      bit p;
      p = m_permit();
      if (!m_lock) m_lock = issue_i && issue_lock_i && p;
      else if (lock_done_i || lock_ni) m_lock = 0;
      m_snoop = (hit_ni == 0) && (hitm_ni == 0);
      m_prio  = (prio_ni == 0);
      if (m_edge % 2 == 1) m_stall = (stall_ni == 0);
      if (m_edge % 2 == 0) m_drive = stall_req_i;
      m_edge++;
    end
  end

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    chk(tag, "issue_ok_o", issue_ok_o, m_permit());
    chk(tag == "R2" ? "R2" : tag, "stall_drive_no", stall_drive_no, !m_drive);
  endtask

  task automatic idle();
    stall_ni = 1; prio_ni = 1; lock_ni = 1; hit_ni = 1; hitm_ni = 1;
    stall_req_i = 0; issue_i = 0; issue_lock_i = 0; lock_done_i = 0;
  endtask

  task automatic take_lock();
    idle(); issue_i = 1; issue_lock_i = 1; lock_ni = 0; step();
    issue_i = 0; issue_lock_i = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "issue_ok_o in reset", issue_ok_o, 1'b1);
    chk("R1", "stall_drive_no in reset", stall_drive_no, 1'b1);
    rst_ni = 1;

    tag = "R2";
    for (int i = 0; i < 24; i++) begin stall_req_i = (i % 3) != 0; step(); end
    idle();
    tag = "R3";
    for (int i = 0; i < 24; i++) begin stall_ni = (i % 5) < 2; step(); end
    stall_ni = 1; step(); step(); step();
    tag = "R4";
    for (int i = 0; i < 16; i++) begin hit_ni = i[0]; hitm_ni = i[1]; step(); end
    idle(); step();
    tag = "R5";
    prio_ni = 0;
    for (int i = 0; i < 8; i++) begin issue_i = i[0]; step(); end
    idle(); step();
    tag = "R6";
    take_lock(); prio_ni = 0; lock_ni = 0;
    for (int i = 0; i < 8; i++) begin issue_i = i[0]; issue_lock_i = i[0]; step(); end
    tag = "R7";
    lock_done_i = 1; step(); lock_done_i = 0;
    for (int i = 0; i < 4; i++) step();
    idle(); step();
    tag = "R8";
    take_lock(); prio_ni = 0; lock_ni = 0; step(); step();
    lock_ni = 1; step(); step(); step();
    idle(); step();
    tag = "R9";
    hit_ni = 0; hitm_ni = 0; step();
    issue_i = 1; issue_lock_i = 1; lock_ni = 0; step();
    idle(); prio_ni = 0; lock_ni = 0; step(); step(); step();
    idle(); step();

    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      stall_ni     = ($urandom_range(0, 5) != 0);
      prio_ni      = ($urandom_range(0, 2) != 0);
      lock_ni      = ($urandom_range(0, 6) == 0);
      hit_ni       = ($urandom_range(0, 3) != 0);
      hitm_ni      = ($urandom_range(0, 3) != 0);
      stall_req_i  = $urandom_range(0, 1);
      issue_i      = $urandom_range(0, 1);
      issue_lock_i = $urandom_range(0, 1);
      lock_done_i  = ($urandom_range(0, 9) == 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule